// File: doc/BRIEF.md
# End-of-Conversion Notifier

This block collects completion events from four converter channels and tells two consumers about them. Nearby programmable logic gets a one-cycle done pulse per channel, with no masking. A processor gets a sticky status nibble and an interrupt line. The interrupt is gated per channel by a mask. A processor read of the status nibble clears both the nibble and the interrupt. The two paths run side by side and neither disturbs the other.

Each converter raises its completion line. The block acts on the rising edge of that line, so a line held high counts as one completion. Converters can be grouped into wider ones: a low pair (channels 0 and 1), a high pair (channels 2 and 3), or all four together. A group reports only through its first channel. Events from the other members of the group are folded onto that first channel.

Top module: `eoc_notify`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done_pulse`, `status` and `irq` are all zero.
- R2: A rising edge on `conv_end[i]` (low at one clock edge, high at the next) makes `done_pulse[i]` high for exactly the following clock cycle. A line that stays high produces no further pulses.
- R3: The clock edge that sees a completion on channel i sets `status[i]`. The bit stays 1 at every later edge where `stat_rd` is low.
- R4: `irq` is registered. After each edge it equals the OR over i of `status[i] AND irq_mask[i]`, using the mask value sampled at that edge. A completion on a channel whose mask bit is 0 sets the status bit but leaves `irq` low, and raising that mask bit later raises `irq` at the next edge.
- R5: An edge that sees `stat_rd` high clears every status bit that has no new completion in that same cycle, and `irq` follows.
- R6: When a completion and `stat_rd` fall in the same cycle, the completing channel's status bit ends up set (1). All other bits are cleared, and `irq` reflects the bit that remains.
- R7: Grouping is controlled by three inputs:
  - With `grp_lo`=1, events on channel 1 are reported on bit 0.
  - With `grp_hi`=1, events on channel 3 are reported on bit 2.
  - With `grp_all`=1, events on channels 1, 2 and 3 are reported on bit 0; this input overrides the other two.
  - A folded-away bit never pulses and never sets, whether in `done_pulse` or in `status`.
- R8: `done_pulse` ignores both `irq_mask` and `stat_rd`. A completion pulses its bit even when that channel is masked, and even during a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_end | input | 4 | Per-channel completion lines from the converters |
| grp_lo | input | 1 | Channels 0 and 1 form one converter |
| grp_hi | input | 1 | Channels 2 and 3 form one converter |
| grp_all | input | 1 | All four channels form one converter |
| irq_mask | input | 4 | Per-channel interrupt enable, 1 = enabled |
| stat_rd | input | 1 | Strobe for a processor read of the status nibble |
| done_pulse | output | 4 | One-cycle completion pulse to programmable logic |
| status | output | 4 | Sticky completion status nibble |
| irq | output | 1 | Masked interrupt request to the processor |

## Verification
The bench holds a completion line high for two cycles. A level-sensitive design would pulse twice or stretch the pulse. It lands a read in the same cycle as a new completion. A design that lets the read win would lose that event and drop the interrupt. It completes a masked channel and then unmasks it. A design that samples the mask only at completion time would never raise the interrupt. It also drives events on the non-leading channels of each grouping, which catches a fold that sets the wrong bit or forgets to clear a member bit.

// File: rtl/eoc_notify.sv
module eoc_notify (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] conv_end,
  input  logic       grp_lo,
  input  logic       grp_hi,
  input  logic       grp_all,
  input  logic [3:0] irq_mask,
  input  logic       stat_rd,
  output logic [3:0] done_pulse,
  output logic [3:0] status,
  output logic       irq
);

  logic [3:0] line_q;
  logic [3:0] rise;
  logic [3:0] evt;
  logic [3:0] st_nxt;

  assign rise = conv_end & ~line_q;

  always_comb begin
    evt = rise;
    if (grp_all) begin
      evt = {3'b000, |rise};
    end else begin
      if (grp_lo) evt[1:0] = {1'b0, rise[0] | rise[1]};
      if (grp_hi) evt[3:2] = {1'b0, rise[2] | rise[3]};
    end
  end

  assign st_nxt = (stat_rd ? 4'b0000 : status) | evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= 4'b0000;
      done_pulse <= 4'b0000;
      status     <= 4'b0000;
      irq        <= 1'b0;
    end else begin
      line_q     <= conv_end;
      done_pulse <= evt;
      status     <= st_nxt;
      irq        <= |(st_nxt & irq_mask);
    end
  end

endmodule

// File: rtl/eoc_notify_chk.sv
module eoc_notify_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       grp_lo,
  input logic       grp_hi,
  input logic       grp_all,
  input logic [3:0] irq_mask,
  input logic       stat_rd,
  input logic [3:0] done_pulse,
  input logic [3:0] status,
  input logic       irq
);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status & $past(status)) == $past(status)));

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq == |(status & $past(irq_mask))));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (status == done_pulse));

  assert_pulse_in_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse & ~status) == 4'b0000);

  assert_lo_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_lo || grp_all) |=> !done_pulse[1]);

  assert_hi_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_hi || grp_all) |=> !done_pulse[3]);

  assert_all_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grp_all |=> !done_pulse[2]);

endmodule

bind eoc_notify eoc_notify_chk chk (
  .clk(clk), .rst_n(rst_n), .grp_lo(grp_lo), .grp_hi(grp_hi), .grp_all(grp_all),
  .irq_mask(irq_mask), .stat_rd(stat_rd), .done_pulse(done_pulse),
  .status(status), .irq(irq)
);

// File: tb/eoc_notify_test.sv
module eoc_notify_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] conv_end = 4'b0;
  logic       grp_lo = 1'b0, grp_hi = 1'b0, grp_all = 1'b0;
  logic [3:0] irq_mask = 4'b0;
  logic       stat_rd = 1'b0;
  logic [3:0] done_pulse, status;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] pd;
    logic [3:0] st;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t sb[$];

  logic [3:0] m_line = 4'b0;
  logic [3:0] m_st = 4'b0;

  always #10 clk = ~clk;

  eoc_notify uut (
    .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .grp_lo(grp_lo),
    .grp_hi(grp_hi), .grp_all(grp_all), .irq_mask(irq_mask), .stat_rd(stat_rd),
    .done_pulse(done_pulse), .status(status), .irq(irq)
  );

  task automatic check(string tag, logic [3:0] pd, logic [3:0] st, logic iq);
    checks++;
    if (done_pulse !== pd || status !== st || irq !== iq) begin
      fails++;
      $display("FAIL %s: got pulse=%b status=%b irq=%b, expected pulse=%b status=%b irq=%b",
               tag, done_pulse, status, irq, pd, st, iq);
    end
  endtask

  task automatic step(string tag, logic [3:0] ev, logic rd, logic [3:0] mask,
                      logic lo, logic hi, logic all);
    logic [3:0] r;
    logic [3:0] e;
    exp_t x;
    @(negedge clk);
    conv_end = ev; stat_rd = rd; irq_mask = mask;
    grp_lo = lo; grp_hi = hi; grp_all = all;
    r = ev & ~m_line;
    m_line = ev;
    e = r;
    if (all) e = {3'b000, |r};
    else begin
      if (lo) e[1:0] = {1'b0, r[0] | r[1]};
      if (hi) e[3:2] = {1'b0, r[2] | r[3]};
    end
    m_st = (rd ? 4'b0 : m_st) | e;
    x.pd = e; x.st = m_st; x.irq = |(m_st & mask); x.tag = tag;
    sb.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        check(x.tag, x.pd, x.st, x.irq);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 check("R1 in reset", 4'b0, 4'b0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    step("R1 after reset", 4'b0000, 0, 4'b1111, 0, 0, 0);
    step("R2 rising edge ch0", 4'b0001, 0, 4'b1111, 0, 0, 0);
    step("R2 held line no repulse", 4'b0001, 0, 4'b1111, 0, 0, 0);
    step("R3 status sticky", 4'b0000, 0, 4'b1111, 0, 0, 0);
    step("R3 still sticky", 4'b0000, 0, 4'b1111, 0, 0, 0);
    step("R5 read clears", 4'b0000, 1, 4'b1111, 0, 0, 0);
    step("R4 masked ch1 no irq R8 pulse", 4'b0010, 0, 4'b0000, 0, 0, 0);
    step("R4 masked stays low", 4'b0000, 0, 4'b0000, 0, 0, 0);
    step("R4 unmask raises irq", 4'b0000, 0, 4'b0010, 0, 0, 0);
    step("R6 read with ch2 completion R8", 4'b0100, 1, 4'b0100, 0, 0, 0);
    step("R6 bit kept", 4'b0000, 0, 4'b0100, 0, 0, 0);
    step("R2 two channels at once", 4'b1001, 0, 4'b1000, 0, 0, 0);
    step("R5 read clears all", 4'b0000, 1, 4'b1111, 0, 0, 0);
    step("R7 low pair ch1 folds to bit0", 4'b0010, 0, 4'b1111, 1, 0, 0);
    step("R7 idle", 4'b0000, 0, 4'b1111, 1, 0, 0);
    step("R7 high pair ch3 folds to bit2", 4'b1000, 0, 4'b1111, 0, 1, 0);
    step("R5 clear", 4'b0000, 1, 4'b1111, 0, 0, 0);
    step("R7 quad fold to bit0", 4'b1110, 0, 4'b1111, 1, 1, 1);
    step("R7 quad idle", 4'b0000, 0, 4'b1111, 0, 0, 1);
    step("R7 quad ch2 only", 4'b0100, 1, 4'b1111, 0, 0, 1);
    step("R8 read with no event", 4'b0000, 1, 4'b1111, 0, 0, 0);
    step("R4 no events masked", 4'b0011, 0, 4'b1100, 0, 0, 0);
    step("R5 final read", 4'b0000, 1, 4'b1111, 0, 0, 0);
    step("R1 drain", 4'b0000, 0, 4'b1111, 0, 0, 0);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule